// File: doc/BRIEF.md
# Latched Alert Status Controller

This block drives the active-low alert line of a power-management bus slave. It watches a vector of fault and warning conditions: input voltage out of range, output over-current, over-temperature, fan failure, communication error, packet-check error, invalid command and internal fault. A change in any one of them, whether the condition is rising or falling, pulls the alert low. The alert then stays low until a clear event arrives.

A sticky status vector records every condition that has become active since the last clear. The host reads it back as the status word. Four events clear both the alert and the sticky vector: a clear-faults command pulse, a completed status-word read pulse, an off-then-on cycle of the output enable pin, and an off-then-on sequence of operation-command writes. If a condition is still active when a clear takes effect, the block drives the alert low again on the following cycle and records that condition again.

Top module: `alert_status_ctl`

## Requirements
- R1: After reset, alert_n_o is 1 and status_o is all zeros.
- R2: A change of any bit of cond_i, either 0 to 1 or 1 to 0, that is first sampled at rising edge k drives alert_n_o to 0 after edge k+2.
- R3: Once alert_n_o is 0, it stays 0 until a clear event, even after the triggering condition has returned to 0.
- R4: A one-cycle clr_faults_i pulse sampled at an edge sets alert_n_o to 1 and status_o to zero at that edge.
- R5: A one-cycle status_rd_i pulse sampled at an edge releases the alert at that edge and clears status_o.
- R6: Sampling out_en_i at 1 on the edge after it was sampled at 0 is a clear event. out_en_i held at 1, or at 0, has no effect on the alert.
- R7: An op_wr_i pulse with op_on_i=1 is a clear event only if the most recent earlier op_wr_i carried op_on_i=0. An "on" write without a prior "off" write has no effect.
- R8: If a condition is still active when a clear takes effect, alert_n_o is 1 for exactly one cycle and then returns to 0. The status bit of each still-active condition is set again at that same edge.
- R9: Bit i of status_o is set at the edge where a 0-to-1 change of cond_i[i] is detected. A falling condition does not clear it, and a rise detected at the same edge as a clear leaves the bit set.
- R10: A condition change detected at the same edge as a clear event leaves alert_n_o at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cond_i | input | COND_W | Asynchronous condition levels; bit order: vin, iout, temp, fan, comm, pec, bad cmd, internal |
| clr_faults_i | input | 1 | One-cycle clear-faults command pulse |
| status_rd_i | input | 1 | One-cycle completed status-word read pulse |
| out_en_i | input | 1 | Synchronous output enable pin level |
| op_wr_i | input | 1 | One-cycle operation-command write pulse |
| op_on_i | input | 1 | Output state carried by the operation write, 1 = on |
| alert_n_o | output | 1 | Active-low latched alert |
| status_o | output | COND_W | Sticky status vector |

## Verification
A condition change reaches the outputs three edges after it is first sampled: two edges cross the synchronizer and the third loads the alert and status registers. A clear pulse acts at the same edge that samples it, and a relatch follows one edge later. The bench drives every input on falling edges. Its directed checks count rising edges from the stimulus to those exact due edges. A behavioural model advances on every rising edge, and the bench compares it with both outputs at every falling edge, so that a result arriving early or late shows up as a mismatch.

// File: rtl/alert_status_pkg.sv
package alert_status_pkg;
  localparam int unsigned COND_W = 8;

  typedef enum logic [2:0] {
    C_VIN      = 3'd0,
    C_IOUT_OC  = 3'd1,
    C_TEMP     = 3'd2,
    C_FAN      = 3'd3,
    C_COMM     = 3'd4,
    C_PEC      = 3'd5,
    C_BAD_CMD  = 3'd6,
    C_INTERNAL = 3'd7
  } cond_idx_e;

  typedef struct packed {
    logic faults_cmd;
    logic status_rd;
    logic pin_cycle;
    logic op_cycle;
  } clr_src_t;
endpackage

// File: rtl/alert_sync.sv
module alert_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stage_q[g] <= '0;
        else         stage_q[g] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stage_q[g] <= '0;
        else         stage_q[g] <= stage_q[g-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/alert_change_det.sv
module alert_change_det #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] change_o,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= d_i;

  assign change_o = d_i ^ prev_q;
  assign rise_o   = d_i & ~prev_q;
endmodule

// File: rtl/alert_clear_ctl.sv
module alert_clear_ctl
  import alert_status_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     clr_faults_i,
  input  logic     status_rd_i,
  input  logic     out_en_i,
  input  logic     op_wr_i,
  input  logic     op_on_i,
  output clr_src_t src_o,
  output logic     clr_o
);
  logic en_off_q, op_off_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      en_off_q <= 1'b0;
      op_off_q <= 1'b0;
    end else begin
      en_off_q <= ~out_en_i;
      if (op_wr_i) op_off_q <= ~op_on_i;
    end

  always_comb begin
    src_o.faults_cmd = clr_faults_i;
    src_o.status_rd  = status_rd_i;
    src_o.pin_cycle  = out_en_i & en_off_q;
    src_o.op_cycle   = op_wr_i & op_on_i & op_off_q;
  end

  assign clr_o = |src_o;

  // a pin cycle consumes the off flag
  assert_pin_once_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_o.pin_cycle |=> !src_o.pin_cycle);
endmodule

// File: rtl/alert_status_ctl.sv
module alert_status_ctl
  import alert_status_pkg::*;
#(
  parameter int unsigned COND_W      = alert_status_pkg::COND_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [COND_W-1:0] cond_i,
  input  logic              clr_faults_i,
  input  logic              status_rd_i,
  input  logic              out_en_i,
  input  logic              op_wr_i,
  input  logic              op_on_i,
  output logic              alert_n_o,
  output logic [COND_W-1:0] status_o
);
  logic [COND_W-1:0] cond_s, change, rise, status_q, status_d;
  logic              alert_q, alert_set, rearm_q, clr_any;
  clr_src_t          clr_src;

  alert_sync #(.W(COND_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(cond_i), .q_o(cond_s)
  );

  alert_change_det #(.W(COND_W)) u_det (
    .clk_i, .rst_ni, .d_i(cond_s), .change_o(change), .rise_o(rise)
  );

  alert_clear_ctl u_clr (
    .clk_i, .rst_ni,
    .clr_faults_i, .status_rd_i, .out_en_i, .op_wr_i, .op_on_i,
    .src_o(clr_src), .clr_o(clr_any)
  );

  // relatch on the cycle after a clear if anything is still active
  assign alert_set = (|change) | (rearm_q & (|cond_s));
  assign status_d  = (clr_any ? '0 : status_q) | rise | (rearm_q ? cond_s : '0);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      alert_q  <= 1'b0;
      rearm_q  <= 1'b0;
      status_q <= '0;
    end else begin
      rearm_q  <= clr_any;
      status_q <= status_d;
      if (alert_set)    alert_q <= 1'b1;
      else if (clr_any) alert_q <= 1'b0;
    end

  assign alert_n_o = ~alert_q;
  assign status_o  = status_q;

  assert_change_alerts_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|change) |=> !alert_n_o);

  assert_latch_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!alert_n_o && !clr_any) |=> !alert_n_o);

  assert_faults_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_src.faults_cmd && !(|change) && !(|rise) && !rearm_q) |=> (alert_n_o && status_o == '0));

  assert_relatch_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_any && (|cond_s)) |=> ##1 !alert_n_o);

  assert_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_any |=> ((status_o & $past(status_o)) == $past(status_o)));
endmodule

// File: tb/alert_status_ctl_test.sv
module alert_status_ctl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NC-1:0] cond = '0;
  logic          clr_f = 1'b0, st_rd = 1'b0, en = 1'b1, op_wr = 1'b0, op_on = 1'b0;
  logic          alert_n;
  logic [NC-1:0] status;

  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alert_status_ctl uut (
    .clk_i(clk), .rst_ni(rst_n), .cond_i(cond),
    .clr_faults_i(clr_f), .status_rd_i(st_rd), .out_en_i(en),
    .op_wr_i(op_wr), .op_on_i(op_on),
    .alert_n_o(alert_n), .status_o(status)
  );

  // behavioural reference
  logic [NC-1:0] m_pipe[$];
  logic [NC-1:0] m_last, m_stat, m_seen;
  bit m_alert, m_rearm, m_en_was_off, m_op_was_off;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pipe = {'0, '0};
      m_last = '0; m_stat = '0;
      m_alert = 0; m_rearm = 0; m_en_was_off = 0; m_op_was_off = 0;
    end else begin
      bit clr;
      m_seen = m_pipe[0];
      clr = clr_f || st_rd || (en && m_en_was_off) || (op_wr && op_on && m_op_was_off);
      if ((m_seen != m_last) || (m_rearm && m_seen != 0)) m_alert = 1;
      else if (clr) m_alert = 0;
      if (clr) m_stat = '0;
      m_stat = m_stat | (m_seen & ~m_last);
      if (m_rearm) m_stat = m_stat | m_seen;
      m_rearm = clr;
      m_last = m_seen;
      void'(m_pipe.pop_front());
      m_pipe.push_back(cond);
      m_en_was_off = !en;
      if (op_wr) m_op_was_off = !op_on;
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    checks++;
    if (alert_n !== !m_alert) begin
      failures++;
      $display("FAIL R2/R3 model alert_n act=%0b exp=%0b t=%0t", alert_n, !m_alert, $time);
    end
    checks++;
    if (status !== m_stat) begin
      failures++;
      $display("FAIL R9 model status act=%h exp=%h t=%0t", status, m_stat, $time);
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic pulse_clr();
    clr_f = 1; tick(); clr_f = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 alert", alert_n, 1);
    chk("R1 status", status, 0);

    // R2 latency: driven here, sampled at next edge k
    cond[1] = 1;
    tick(2);
    chk("R2 before due", alert_n, 1);
    tick();
    chk("R2 due", alert_n, 0);
    chk("R9 set", status, 8'h02);

    cond[1] = 0;
    tick(6);
    chk("R3 held", alert_n, 0);
    chk("R9 kept on fall", status, 8'h02);

    pulse_clr();
    chk("R4 alert", alert_n, 1);
    chk("R4 status", status, 0);
    tick(3);
    chk("R4 stays", alert_n, 1);

    // R5 and R8: condition still active at a status read
    cond[3] = 1;
    tick(4);
    st_rd = 1; tick(); st_rd = 0;
    chk("R5 alert", alert_n, 1);
    chk("R5 status", status, 0);
    tick();
    chk("R8 relatch", alert_n, 0);
    chk("R8 status", status, 8'h08);
    cond[3] = 0;
    tick(4);
    pulse_clr();
    tick(2);

    // R6: enable pin
    cond[6] = 1; tick(4); cond[6] = 0; tick(4);
    chk("R6 set", alert_n, 0);
    tick(3);
    chk("R6 high no effect", alert_n, 0);
    en = 0; tick();
    chk("R6 off alone", alert_n, 0);
    en = 1; tick();
    chk("R6 cycle", alert_n, 1);
    chk("R6 status", status, 0);

    // R7: operation command
    cond[7] = 1; tick(4); cond[7] = 0; tick(4);
    op_wr = 1; op_on = 1; tick(); op_wr = 0;
    chk("R7 on alone", alert_n, 0);
    op_wr = 1; op_on = 0; tick(); op_wr = 0;
    chk("R7 off alone", alert_n, 0);
    tick(2);
    op_wr = 1; op_on = 1; tick(); op_wr = 0;
    chk("R7 cycle", alert_n, 1);

    // R9/R10: rise and clear at the same edge
    tick(2);
    cond[0] = 1;
    tick(2);
    clr_f = 1; tick(); clr_f = 0;
    chk("R10 alert", alert_n, 0);
    chk("R9 same edge", status, 8'h01);
    cond[0] = 0; tick(4); pulse_clr(); tick(2);

    // mixed stimulus against the model
    for (int i = 0; i < 600; i++) begin
      if ($urandom_range(0, 5) == 0) cond[$urandom_range(0, NC-1)] ^= 1'b1;
      clr_f = ($urandom_range(0, 15) == 0);
      st_rd = ($urandom_range(0, 15) == 0);
      if ($urandom_range(0, 9) == 0) en = ~en;
      op_wr = ($urandom_range(0, 7) == 0);
      op_on = $urandom_range(0, 1);
      tick();
    end
    clr_f = 0; st_rd = 0; op_wr = 0;
    tick(2);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule